// File: doc/BRIEF.md
# Verify-Path Key Scrambler and Lock Guard

This block sits between the on-chip program store and the verify read port. It keeps a key table of 64 bytes and three lock bits in a security store. Each verify read returns one of three things. With the chip locked, it returns all ones. With any key byte programmed, it returns the stored byte XNOR-ed with a key byte. Otherwise it returns the stored byte unchanged.

The store behaves like erased flash. Key bytes and lock bits start at all ones after an erase. A program write can only turn bits from 1 to 0, so the protection level can only rise. The only way back to the blank state is the erase input. The store is not touched by the block reset. Reset clears only the registered verify output.

Top module: `verify_guard`

## Requirements
- R1: While `rst` is high, `rd_valid_o` and `rd_data_o` go to 0 on the next clock edge. Reset leaves the key table, the lock bits, `crypt_on_o` and `lock_level_o` as they were.
- R2: A cycle with `erase_i` high sets every key byte to FFh and every lock bit to 1. From the next cycle, `crypt_on_o` is 0 and `lock_level_o` is 0.
- R3: With `lock_level_o` at 0 and `crypt_on_o` at 0, a verify read returns `rd_data_i` unchanged.
- R4: A key write stores the bitwise AND of the old byte and `key_wr_data_i`. Writing a 1 over a programmed 0 has no effect.
- R5: `crypt_on_o` goes to 1 in the cycle after a key write leaves any key byte different from FFh. It stays at 1 until an erase.
- R6: With `crypt_on_o` at 1 and the level at 0, a verify read returns `~(rd_data_i ^ key[rd_idx_i])`. `rd_idx_i` carries the low 6 bits of the verify address. A key byte still at FFh therefore passes data through unchanged.
- R7: A lock write stores the AND of the old lock bits and `lock_wr_data_i`. The level on `lock_level_o` is decided by priority: bit 2 at 0 gives 3, otherwise bit 1 at 0 gives 2, otherwise bit 0 at 0 gives 1, and all ones gives 0.
- R8: A lock write cannot return a bit to 1, and `lock_level_o` never decreases except through an erase.
- R9: With `lock_level_o` nonzero, every verify read returns FFh, whatever the key table holds.
- R10: When an erase and a key or lock write fall in the same cycle, the erase wins and the write is dropped.
- R11: A verify read in the same cycle as a key write uses the key table as it was before that write.
- R12: `rd_valid_o` is high exactly in the cycle after each cycle with `rd_req_i` high, and the result appears on `rd_data_o` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| erase_i | input | 1 | Mass erase of the key table and the lock bits |
| key_wr_i | input | 1 | Program one key byte |
| key_wr_addr_i | input | 6 | Key byte index to program |
| key_wr_data_i | input | 8 | Value ANDed into the key byte |
| lock_wr_i | input | 1 | Program the lock bits |
| lock_wr_data_i | input | 3 | Value ANDed into the lock bits |
| rd_req_i | input | 1 | Verify read request |
| rd_idx_i | input | 6 | Low verify address bits that select the key byte |
| rd_data_i | input | 8 | Raw byte from the program store |
| rd_valid_o | output | 1 | Verify result valid |
| rd_data_o | output | 8 | Verify result byte |
| crypt_on_o | output | 1 | Scrambling active |
| lock_level_o | output | 2 | Current protection level, 0 to 3 |

## Verification
The bench builds the block with its default key table of 64 bytes. The read index can then reach both the first and the last key byte, and the check compares against a full 64-entry model. It writes bytes at both ends of the table and in the middle. This exposes a wrong index decode or a key byte that fails to hold its AND-only value. Because all three lock bits exist, the bench can step the level through every value from 0 to 3. It also tries to raise a bit at each step and confirms that the level never drops.

// File: rtl/vguard_pkg.sv
package vguard_pkg;

    localparam int BYTE_W    = 8;
    localparam int LOCK_BITS = 3;
    localparam int LEVEL_W   = 2;

    typedef enum logic [LEVEL_W-1:0] {
        LVL_OPEN = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2,
        LVL_TOP  = 2'd3
    } lock_level_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } vresult_t;

    // Highest programmed (zero) lock bit sets the level.
    function automatic lock_level_e level_of(input logic [LOCK_BITS-1:0] lb);
        if (!lb[2])      return LVL_TOP;
        else if (!lb[1]) return LVL_TWO;
        else if (!lb[0]) return LVL_ONE;
        else             return LVL_OPEN;
    endfunction

    function automatic logic [BYTE_W-1:0] scramble(input logic [BYTE_W-1:0] d,
                                                  input logic [BYTE_W-1:0] k);
        return ~(d ^ k);
    endfunction

endpackage

// File: rtl/vg_key_store.sv
module vg_key_store
    import vguard_pkg::*;
#(
    parameter int KEY_BYTES = 64,
    localparam int KW = $clog2(KEY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_i,
    input  logic              wr_i,
    input  logic [KW-1:0]     wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [KW-1:0]     rd_idx_i,
    output logic [BYTE_W-1:0] key_o,
    output logic              active_o
);

    logic [BYTE_W-1:0] key_q [KEY_BYTES];
    logic              active_q;
    logic [BYTE_W-1:0] merged;

    assign merged = key_q[wr_addr_i] & wr_data_i;

    // Store bits are not reset: they model nonvolatile cells.
    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (erase_i)
                key_q[g] <= '1;
            else if (wr_i && wr_addr_i == KW'(g))
                key_q[g] <= key_q[g] & wr_data_i;
        end

        AST_KEY_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
            !$past(erase_i) |-> ((key_q[g] & ~$past(key_q[g])) == '0)); // R4

        AST_KEY_ERASED: assert property (@(posedge clk) disable iff (rst)
            $past(erase_i) |-> (key_q[g] == '1)); // R2
    end

    // Sticky enable flag, updated alongside the programming write.
    always_ff @(posedge clk) begin
        if (erase_i)
            active_q <= 1'b0;
        else if (wr_i && merged != '1)
            active_q <= 1'b1;
    end

    assign key_o    = key_q[rd_idx_i];
    assign active_o = active_q;

    // Independent full scan of the table, used only to check the flag.
    logic any_programmed;
    always_comb begin
        any_programmed = 1'b0;
        for (int i = 0; i < KEY_BYTES; i++)
            any_programmed = any_programmed | (key_q[i] != '1);
    end

    AST_FLAG_TRACKS_TABLE: assert property (@(posedge clk) disable iff (rst)
        active_q == any_programmed); // R5

endmodule

// File: rtl/vg_lock_bits.sv
module vg_lock_bits
    import vguard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase_i,
    input  logic                 wr_i,
    input  logic [LOCK_BITS-1:0] wr_data_i,
    output lock_level_e          level_o
);

    logic [LOCK_BITS-1:0] lb_q;

    always_ff @(posedge clk) begin
        if (erase_i)
            lb_q <= '1;
        else if (wr_i)
            lb_q <= lb_q & wr_data_i;
    end

    assign level_o = level_of(lb_q);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(erase_i) |-> ((lb_q & ~$past(lb_q)) == '0)); // R8

    AST_LEVEL_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !$past(erase_i) |-> (level_o >= $past(level_o))); // R8

    AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (rst)
        $past(erase_i) |-> (level_o == LVL_OPEN)); // R10

endmodule

// File: rtl/vg_verify_out.sv
module vg_verify_out
    import vguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] key_i,
    input  logic              crypt_on_i,
    input  lock_level_e       level_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o
);

    vresult_t res_q;
    logic [BYTE_W-1:0] shaped;

    always_comb begin
        if (level_i != LVL_OPEN)
            shaped = '1;
        else if (crypt_on_i)
            shaped = scramble(data_i, key_i);
        else
            shaped = data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= req_i;
            if (req_i)
                res_q.data <= shaped;
        end
    end

    assign valid_o = res_q.valid;
    assign data_o  = res_q.data;

    AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(req_i)); // R12

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        ($past(req_i) && !$past(rst)) |-> valid_o); // R12

    AST_LOCKED_BLANK: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(level_i != LVL_OPEN)) |-> (data_o == '1)); // R9

    AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(level_i == LVL_OPEN && !crypt_on_i)) |-> (data_o == $past(data_i))); // R3

endmodule

// File: rtl/verify_guard.sv
module verify_guard
    import vguard_pkg::*;
#(
    parameter int KEY_BYTES = 64,
    localparam int KW = $clog2(KEY_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase_i,
    input  logic                 key_wr_i,
    input  logic [KW-1:0]        key_wr_addr_i,
    input  logic [BYTE_W-1:0]    key_wr_data_i,
    input  logic                 lock_wr_i,
    input  logic [LOCK_BITS-1:0] lock_wr_data_i,
    input  logic                 rd_req_i,
    input  logic [KW-1:0]        rd_idx_i,
    input  logic [BYTE_W-1:0]    rd_data_i,
    output logic                 rd_valid_o,
    output logic [BYTE_W-1:0]    rd_data_o,
    output logic                 crypt_on_o,
    output logic [LEVEL_W-1:0]   lock_level_o
);

    logic [BYTE_W-1:0] key_byte;
    logic              active;
    lock_level_e       level;

    vg_key_store #(.KEY_BYTES(KEY_BYTES)) i_keys (
        .clk       (clk),
        .rst       (rst),
        .erase_i   (erase_i),
        .wr_i      (key_wr_i),
        .wr_addr_i (key_wr_addr_i),
        .wr_data_i (key_wr_data_i),
        .rd_idx_i  (rd_idx_i),
        .key_o     (key_byte),
        .active_o  (active)
    );

    vg_lock_bits i_lock (
        .clk       (clk),
        .rst       (rst),
        .erase_i   (erase_i),
        .wr_i      (lock_wr_i),
        .wr_data_i (lock_wr_data_i),
        .level_o   (level)
    );

    vg_verify_out i_out (
        .clk        (clk),
        .rst        (rst),
        .req_i      (rd_req_i),
        .data_i     (rd_data_i),
        .key_i      (key_byte),
        .crypt_on_i (active),
        .level_i    (level),
        .valid_o    (rd_valid_o),
        .data_o     (rd_data_o)
    );

    assign crypt_on_o   = active;
    assign lock_level_o = level;

    AST_ERASE_CLEARS_CRYPT: assert property (@(posedge clk) disable iff (rst)
        $past(erase_i) |-> !crypt_on_o); // R2

endmodule

// File: tb/test_verify_guard.sv
module test_verify_guard;

    localparam int NK = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       erase_i;
    logic       key_wr_i;
    logic [5:0] key_wr_addr_i;
    logic [7:0] key_wr_data_i;
    logic       lock_wr_i;
    logic [2:0] lock_wr_data_i;
    logic       rd_req_i;
    logic [5:0] rd_idx_i;
    logic [7:0] rd_data_i;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic       crypt_on_o;
    logic [1:0] lock_level_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] km [NK];
    logic [2:0] lbm;

    always #2 clk = ~clk;

    verify_guard #(.KEY_BYTES(NK)) i_verify_guard (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] mlevel();
        if (!lbm[2]) return 2'd3;
        if (!lbm[1]) return 2'd2;
        if (!lbm[0]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic mcrypt();
        for (int i = 0; i < NK; i++) if (km[i] != 8'hFF) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] mexp(input logic [7:0] d, input logic [5:0] idx);
        if (mlevel() != 2'd0) return 8'hFF;
        if (mcrypt()) return ~(d ^ km[idx]);
        return d;
    endfunction

    task automatic merase();
        for (int i = 0; i < NK; i++) km[i] = 8'hFF;
        lbm = 3'b111;
    endtask

    task automatic do_erase();
        @(negedge clk); erase_i = 1'b1;
        @(negedge clk); erase_i = 1'b0;
        merase();
    endtask

    task automatic key_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); key_wr_i = 1'b1; key_wr_addr_i = a; key_wr_data_i = d;
        @(negedge clk); key_wr_i = 1'b0;
        km[a] = km[a] & d;
    endtask

    task automatic lock_write(input logic [2:0] d);
        @(negedge clk); lock_wr_i = 1'b1; lock_wr_data_i = d;
        @(negedge clk); lock_wr_i = 1'b0;
        lbm = lbm & d;
    endtask

    task automatic read_chk(input string req, input logic [5:0] idx, input logic [7:0] d);
        logic [7:0] e;
        e = mexp(d, idx);
        @(negedge clk); rd_req_i = 1'b1; rd_idx_i = idx; rd_data_i = d;
        @(negedge clk); rd_req_i = 1'b0;
        chk({req, " valid"}, 32'(rd_valid_o), 32'd1);
        chk({req, " data"}, 32'(rd_data_o), 32'(e));
    endtask

    task automatic t_reset_state();
        chk("R1 valid after reset", 32'(rd_valid_o), 32'd0);
        chk("R1 data after reset", 32'(rd_data_o), 32'd0);
        chk("R2 crypt off after erase", 32'(crypt_on_o), 32'd0);
        chk("R2 level open after erase", 32'(lock_level_o), 32'd0);
    endtask

    task automatic t_passthrough();
        read_chk("R3 pass 5A", 6'd0, 8'h5A);
        @(negedge clk);
        chk("R12 valid drops", 32'(rd_valid_o), 32'd0);
        read_chk("R3 pass 00", 6'd63, 8'h00);
        read_chk("R3 pass FF", 6'd17, 8'hFF);
    endtask

    task automatic t_key_program();
        key_write(6'd5, 8'hA5);
        chk("R5 crypt on", 32'(crypt_on_o), 32'd1);
        read_chk("R6 idx5", 6'd5, 8'h3C);
        read_chk("R6 idx63 blank key", 6'd63, 8'h96);
        key_write(6'd5, 8'hFF);
        read_chk("R4 raise ignored", 6'd5, 8'h3C);
        key_write(6'd5, 8'h0F);
        read_chk("R4 and store", 6'd5, 8'hC3);
        key_write(6'd63, 8'h81);
        read_chk("R6 idx63", 6'd63, 8'h7E);
        key_write(6'd0, 8'h00);
        read_chk("R6 idx0", 6'd0, 8'h12);
    endtask

    task automatic t_same_cycle();
        logic [7:0] e;
        e = mexp(8'h6B, 6'd10);
        @(negedge clk);
        key_wr_i = 1'b1; key_wr_addr_i = 6'd10; key_wr_data_i = 8'h00;
        rd_req_i = 1'b1; rd_idx_i = 6'd10; rd_data_i = 8'h6B;
        @(negedge clk);
        key_wr_i = 1'b0; rd_req_i = 1'b0;
        km[10] = 8'h00;
        chk("R11 old key used", 32'(rd_data_o), 32'(e));
        read_chk("R11 new key", 6'd10, 8'h6B);
    endtask

    task automatic t_reset_keeps();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 valid cleared", 32'(rd_valid_o), 32'd0);
        chk("R1 crypt kept", 32'(crypt_on_o), 32'd1);
        read_chk("R1 key kept", 6'd5, 8'h44);
    endtask

    task automatic t_lock_levels();
        lock_write(3'b110);
        chk("R7 level one", 32'(lock_level_o), 32'd1);
        read_chk("R9 blank at one", 6'd5, 8'h3C);
        lock_write(3'b111);
        chk("R8 no raise", 32'(lock_level_o), 32'd1);
        lock_write(3'b101);
        chk("R7 level two", 32'(lock_level_o), 32'd2);
        lock_write(3'b011);
        chk("R7 level top", 32'(lock_level_o), 32'd3);
        lock_write(3'b111);
        chk("R8 stays top", 32'(lock_level_o), 32'd3);
        read_chk("R9 blank at top", 6'd0, 8'h00);
    endtask

    task automatic t_erase();
        do_erase();
        chk("R2 level open", 32'(lock_level_o), 32'd0);
        chk("R2 crypt off", 32'(crypt_on_o), 32'd0);
        read_chk("R2 pass after erase", 6'd5, 8'h3C);
    endtask

    task automatic t_erase_wins();
        @(negedge clk);
        erase_i = 1'b1; key_wr_i = 1'b1; key_wr_addr_i = 6'd9; key_wr_data_i = 8'h00;
        lock_wr_i = 1'b1; lock_wr_data_i = 3'b000;
        @(negedge clk);
        erase_i = 1'b0; key_wr_i = 1'b0; lock_wr_i = 1'b0;
        merase();
        chk("R10 crypt off", 32'(crypt_on_o), 32'd0);
        chk("R10 level open", 32'(lock_level_o), 32'd0);
        read_chk("R10 key dropped", 6'd9, 8'hC7);
    endtask

    initial begin
        rst = 1'b1; erase_i = 1'b1;
        key_wr_i = 1'b0; key_wr_addr_i = '0; key_wr_data_i = '0;
        lock_wr_i = 1'b0; lock_wr_data_i = '0;
        rd_req_i = 1'b0; rd_idx_i = '0; rd_data_i = '0;
        merase();
        repeat (3) @(negedge clk);
        erase_i = 1'b0; rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_passthrough();
        t_key_program();
        t_same_cycle();
        t_reset_keeps();
        t_lock_levels();
        t_erase();
        t_erase_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule